// File: doc/BRIEF.md
# Programmable Tap Delay Controller

This block delays a one-bit data stream by a run-time selectable number of sample-clock cycles. The stream enters a 32-stage chain of sample registers. A 5-bit tap index picks which stage drives the output, so a higher tap means a later output. The active tap is always visible on a count port. Surrounding logic can use this to line up a data bit with its neighbours.

The tap is controlled in one of four modes, picked by a 2-bit select:
- **Fixed:** the tap is held at a build-time value.
- **Stepping:** each enabled cycle moves the tap one position up or down.
- **Direct load:** a strobe copies a parallel vector straight into the tap.
- **Staged load:** a strobe only writes a holding register, and a separate commit strobe moves that value into the active tap.

A ready flag, modelled on a calibration controller, stays low for a fixed number of cycles after reset is released. No tap update is accepted until it rises.

Top module: `tap_delay_ctrl`

## Requirements
- R1: `tap_cnt` is 5 bits wide (0 to 31) and always shows the active tap. While reset is asserted, and directly after it, the tap equals the parameter `INIT_TAP` (default 0).
- R2: A pulse on `din` appears on `dout` after exactly tap+1 rising clock edges, with its width unchanged.
- R3: With `mode_sel` = 0 (fixed) and ready high, the tap returns to `INIT_TAP` on the next edge. It ignores step, load and commit strobes.
- R4: In modes 1, 2 and 3, a cycle with `step_en` high changes the tap by one on the next edge. It goes up when `step_up` is high in that cycle, and down otherwise.
- R5: A step up from tap 31 gives 0, and a step down from tap 0 gives 31.
- R6: With `mode_sel` = 2 (direct load), a `load_stb` cycle places `load_val` in the tap on the next edge.
- R7: In mode 2, when `load_stb` and `step_en` are both high in the same cycle, the load wins and the step is dropped.
- R8: With `mode_sel` = 3 (staged), `load_stb` writes `load_val` only into a holding register and leaves the tap unchanged. A `commit_stb` cycle copies the holding register into the tap on the next edge.
- R9: `ready` is low while `rst_n` is low. It rises exactly `READY_DLY` (default 16) rising edges after `rst_n` is released, and stays high until the next reset.
- R10: While `ready` is low, every step, load and commit request is ignored.
- R11: In mode 1 (stepping), `load_stb` and `commit_stb` have no effect. In mode 2, `commit_stb` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; also times the ready delay |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 0 fixed, 1 stepping, 2 direct load, 3 staged load |
| step_en | input | 1 | Step request for this cycle |
| step_up | input | 1 | Step direction: 1 up, 0 down |
| load_stb | input | 1 | Load strobe (tap in mode 2, holding register in mode 3) |
| load_val | input | 5 | Tap value to load |
| commit_stb | input | 1 | Moves the holding register into the tap (mode 3) |
| din | input | 1 | Data bit to delay |
| dout | output | 1 | Delayed data bit |
| tap_cnt | output | 5 | Active tap index |
| ready | output | 1 | High once the delay may be adjusted |

## Verification
The main function is exercised by a table of update operations. Each operation is followed by a single-cycle pulse on `din`, and the bench measures both its arrival cycle and its width. The table visits taps 0, 2, 3, 2 and 31 through loads and steps, so a tap that moved the wrong way or an off-by-one in the delay gives a different arrival cycle. Further entries cover wrap at both ends, a load and a step in the same cycle, a staged load before and after its commit, and strobes sent in a mode that must ignore them. These separate mode decoding and priority faults from faults in the stepping arithmetic. Directed steps then send a load before `ready` rises and check the exact rise cycle of `ready`.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int TDC_TAPS  = 32;
  localparam int TDC_TAP_W = $clog2(TDC_TAPS);

  typedef logic [TDC_TAP_W-1:0] tap_t;

  typedef enum logic [1:0] {
    MODE_FIXED  = 2'd0,
    MODE_STEP   = 2'd1,
    MODE_LOAD   = 2'd2,
    MODE_STAGED = 2'd3
  } tdc_mode_e;

  // One step along the tap range, wrapping at both ends.
  function automatic tap_t step_tap(tap_t cur, logic up);
    if (up) return (cur == tap_t'(TDC_TAPS - 1)) ? '0 : cur + tap_t'(1);
    else    return (cur == '0) ? tap_t'(TDC_TAPS - 1) : cur - tap_t'(1);
  endfunction

  // Edges from input sample to output for a given tap.
  function automatic int delay_cycles(tap_t t);
    return int'(t) + 1;
  endfunction
endpackage

// File: rtl/tdc_ready_gen.sv
module tdc_ready_gen #(
  parameter int READY_DLY = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  localparam int CW = $clog2(READY_DLY + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (cnt_q != CW'(READY_DLY)) cnt_q <= cnt_q + 1'b1;
  end

  assign ready = (cnt_q == CW'(READY_DLY));
endmodule

// File: rtl/tdc_tap_ctrl.sv
module tdc_tap_ctrl
  import tdc_pkg::*;
#(
  parameter int INIT_TAP = 0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ready,
  input  tdc_mode_e mode,
  input  logic      step_en,
  input  logic      step_up,
  input  logic      load_stb,
  input  tap_t      load_val,
  input  logic      commit_stb,
  output tap_t      tap_q,
  output logic      step_evt,
  output logic      load_evt,
  output logic      commit_evt
);
  tap_t stage_q;
  logic stage_wr;
  logic fixed_evt;

  always_comb begin
    fixed_evt  = ready && (mode == MODE_FIXED);
    load_evt   = ready && load_stb && (mode == MODE_LOAD);
    commit_evt = ready && commit_stb && (mode == MODE_STAGED);
    stage_wr   = ready && load_stb && (mode == MODE_STAGED);
    step_evt   = ready && step_en && (mode != MODE_FIXED) && !load_evt && !commit_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q   <= tap_t'(INIT_TAP);
      stage_q <= tap_t'(INIT_TAP);
    end else begin
      if (fixed_evt)       tap_q <= tap_t'(INIT_TAP);
      else if (load_evt)   tap_q <= load_val;
      else if (commit_evt) tap_q <= stage_q;
      else if (step_evt)   tap_q <= step_tap(tap_q, step_up);
      if (stage_wr)        stage_q <= load_val;
    end
  end
endmodule

// File: rtl/tdc_delay_line.sv
module tdc_delay_line
  import tdc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  tap_t tap,
  output logic dout
);
  logic sr_q [TDC_TAPS];

  for (genvar g = 0; g < TDC_TAPS; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q[g] <= 1'b0;
        else        sr_q[g] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q[g] <= 1'b0;
        else        sr_q[g] <= sr_q[g-1];
      end
    end
  end

  assign dout = sr_q[tap];
endmodule

// File: rtl/tap_delay_ctrl.sv
module tap_delay_ctrl
  import tdc_pkg::*;
#(
  parameter int INIT_TAP  = 0,
  parameter int READY_DLY = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode_sel,
  input  logic                 step_en,
  input  logic                 step_up,
  input  logic                 load_stb,
  input  logic [TDC_TAP_W-1:0] load_val,
  input  logic                 commit_stb,
  input  logic                 din,
  output logic                 dout,
  output logic [TDC_TAP_W-1:0] tap_cnt,
  output logic                 ready
);
  tdc_mode_e mode_e;
  tap_t      tap_w;
  logic      step_evt;
  logic      load_evt;
  logic      commit_evt;

  assign mode_e = tdc_mode_e'(mode_sel);

  tdc_ready_gen #(.READY_DLY(READY_DLY)) u_ready (
    .clk   (clk),
    .rst_n (rst_n),
    .ready (ready)
  );

  tdc_tap_ctrl #(.INIT_TAP(INIT_TAP)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .mode       (mode_e),
    .step_en    (step_en),
    .step_up    (step_up),
    .load_stb   (load_stb),
    .load_val   (load_val),
    .commit_stb (commit_stb),
    .tap_q      (tap_w),
    .step_evt   (step_evt),
    .load_evt   (load_evt),
    .commit_evt (commit_evt)
  );

  tdc_delay_line u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (din),
    .tap   (tap_w),
    .dout  (dout)
  );

  assign tap_cnt = tap_w;
endmodule

// File: rtl/tdc_checker.sv
module tdc_checker
  import tdc_pkg::*;
#(
  parameter int INIT_TAP = 0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ready,
  input logic [1:0] mode_sel,
  input logic       step_en,
  input logic       step_up,
  input logic       load_stb,
  input tap_t       load_val,
  input logic       commit_stb,
  input tap_t       tap_cnt,
  input logic       step_evt,
  input logic       load_evt
);
  assert_fixed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && mode_sel == 2'd0) |=> (tap_cnt == tap_t'(INIT_TAP)));

  assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && mode_sel == 2'd1 && step_en && step_up) |=>
      (tap_cnt == tap_t'($past(tap_cnt) + tap_t'(1))));

  assert_wrap_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && mode_sel == 2'd1 && step_en && !step_up && tap_cnt == '0) |=>
      (tap_cnt == tap_t'(TDC_TAPS - 1)));

  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && mode_sel == 2'd2 && load_stb) |=> (tap_cnt == $past(load_val)));

  assert_load_step_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_evt && step_evt));

  assert_staged_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && mode_sel == 2'd3 && load_stb && !commit_stb && !step_en) |=> $stable(tap_cnt));

  assert_ready_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  assert_idle_unready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(tap_cnt));
endmodule

bind tap_delay_ctrl tdc_checker #(.INIT_TAP(INIT_TAP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready      (ready),
  .mode_sel   (mode_sel),
  .step_en    (step_en),
  .step_up    (step_up),
  .load_stb   (load_stb),
  .load_val   (load_val),
  .commit_stb (commit_stb),
  .tap_cnt    (tap_cnt),
  .step_evt   (step_evt),
  .load_evt   (load_evt)
);

// File: tb/tap_delay_ctrl_tb_top.sv
module tap_delay_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int READY_DLY  = 16;
  localparam int NVEC       = 14;

  localparam logic [2:0] OP_NONE   = 3'd0;
  localparam logic [2:0] OP_UP     = 3'd1;
  localparam logic [2:0] OP_DN     = 3'd2;
  localparam logic [2:0] OP_LOAD   = 3'd3;
  localparam logic [2:0] OP_COMMIT = 3'd4;
  localparam logic [2:0] OP_LDUP   = 3'd5;

  // {mode, op, value, expected tap}
  localparam logic [14:0] VECS [NVEC] = '{
    {2'd2, OP_LOAD,   5'd0,  5'd0},
    {2'd2, OP_LOAD,   5'd2,  5'd2},
    {2'd2, OP_UP,     5'd0,  5'd3},
    {2'd2, OP_DN,     5'd0,  5'd2},
    {2'd2, OP_LOAD,   5'd31, 5'd31},
    {2'd1, OP_UP,     5'd0,  5'd0},
    {2'd1, OP_DN,     5'd0,  5'd31},
    {2'd1, OP_LOAD,   5'd7,  5'd31},
    {2'd2, OP_LDUP,   5'd9,  5'd9},
    {2'd3, OP_LOAD,   5'd20, 5'd9},
    {2'd3, OP_COMMIT, 5'd0,  5'd20},
    {2'd2, OP_COMMIT, 5'd0,  5'd20},
    {2'd0, OP_LOAD,   5'd12, 5'd0},
    {2'd0, OP_UP,     5'd0,  5'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_sel;
  logic       step_en, step_up, load_stb, commit_stb, din;
  logic [4:0] load_val;
  logic       dout, ready;
  logic [4:0] tap_cnt;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tap_delay_ctrl #(.INIT_TAP(0), .READY_DLY(READY_DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .step_en(step_en),
    .step_up(step_up), .load_stb(load_stb), .load_val(load_val),
    .commit_stb(commit_stb), .din(din), .dout(dout), .tap_cnt(tap_cnt),
    .ready(ready)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] m, input logic [2:0] op);
    if (m == 2'd0) return "R3";
    if (op == OP_LDUP) return "R7";
    if (m == 2'd3) return "R8";
    if (m == 2'd1 && op == OP_LOAD) return "R11";
    if (m == 2'd2 && op == OP_COMMIT) return "R11";
    if (m == 2'd1) return "R5";
    if (op == OP_LOAD) return "R6";
    return "R4";
  endfunction

  task automatic measure(input int exp_tap, input string tag);
    int first = 0;
    int highs = 0;
    din = 1'b1;
    for (int c = 1; c <= 40; c++) begin
      @(negedge clk);
      din = 1'b0;
      if (dout) begin
        highs++;
        if (first == 0) first = c;
      end
    end
    check(first == exp_tap + 1, {"R2 arrival after ", tag}, first, exp_tap + 1);
    check(highs == 1, "R2 width", highs, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_sel = 2'd2; step_en = 0; step_up = 0;
    load_stb = 0; commit_stb = 0; load_val = '0; din = 0;
    repeat (3) @(negedge clk);
    check(tap_cnt == 5'd0, "R1 reset tap", tap_cnt, 0);
    check(ready == 1'b0, "R9 ready low in reset", ready, 0);
    check(dout == 1'b0, "R2 dout idle in reset", dout, 0);
    rst_n = 1'b1;
    for (int k = 1; k <= READY_DLY; k++) begin
      @(negedge clk);
      if (k == 3) begin load_stb = 1'b1; load_val = 5'd9; step_en = 1'b1; step_up = 1'b1; end
      if (k == 4) begin
        load_stb = 1'b0; step_en = 1'b0;
        check(tap_cnt == 5'd0, "R10 update before ready", tap_cnt, 0);
      end
      if (k == READY_DLY - 1) check(ready == 1'b0, "R9 ready early", ready, 0);
      if (k == READY_DLY)     check(ready == 1'b1, "R9 ready on time", ready, 1);
    end

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] m;
      logic [2:0] op;
      logic [4:0] v, e;
      {m, op, v, e} = VECS[i];
      mode_sel = m;
      load_val = v;
      load_stb   = (op == OP_LOAD) || (op == OP_LDUP);
      commit_stb = (op == OP_COMMIT);
      step_en    = (op == OP_UP) || (op == OP_DN) || (op == OP_LDUP);
      step_up    = (op == OP_UP) || (op == OP_LDUP);
      @(negedge clk);
      load_stb = 0; commit_stb = 0; step_en = 0; step_up = 0;
      check(tap_cnt == e, {"R1 tap via ", tag_of(m, op)}, tap_cnt, e);
      measure(e, tag_of(m, op));
    end

    mode_sel = 2'd2; load_stb = 1'b1; load_val = 5'd17;
    @(negedge clk);
    load_stb = 1'b0;
    check(tap_cnt == 5'd17, "R6 load before reset", tap_cnt, 17);
    rst_n = 1'b0;
    @(negedge clk);
    check(ready == 1'b0, "R9 ready drops in reset", ready, 0);
    check(tap_cnt == 5'd0, "R1 tap back to init", tap_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule